// File: doc/BRIEF.md
# Edge-Triggered Interrupt Aggregator with Mask

This block is a small interrupt controller that sits beside a processor and merges several external event lines into one interrupt request. Each line is brought into the local clock domain by a two-stage synchroniser. Each rising edge is caught in a sticky flag bit. The flags live in a 16-bit register in which only bit positions 8, 9 and 10 are populated; `irq_in[0]`, `irq_in[1]` and `irq_in[2]` map to those positions. A 16-bit mask register decides which flags may reach the processor. A mask bit of 1 blocks its line and a mask bit of 0 lets it through.

Software uses a plain 16-bit register port with a byte address, a write strobe, write data and combinational read data. The mask register is at byte offset 0x0. The flag register is at byte offset 0x2. A flag write is a clear operation: each 0 in the written word clears that flag, and each 1 leaves it untouched. A handler clears the set M by writing the complement of M. Masking only gates the output. A masked line still records its edges, so software can poll it.

The combined request `irq_out` comes from a two-state machine. The states are QUIET and RAISED. Transition RAISE goes from QUIET to RAISED when any unmasked flag is set. Transition DROP goes from RAISED to QUIET when none is set. In every other case the state holds. Because the state is a register, `irq_out` follows a flag or mask change one clock later.

Top module: `irq_edge_agg`

## Requirements
- R1: After reset the mask reads 0x0700 (all populated lines blocked), the flag register reads 0x0000 and `irq_out` is 0.
- R2: A write to byte offset 0x2 clears each flag whose written bit is 0 and leaves each flag whose written bit is 1 unchanged.
- R3: The mask register at byte offset 0x0 reads back the last value written. A 1 in bit 8+i blocks line i from `irq_out`. Writing 0x0700 blocks all three lines.
- R4: If a rising edge reaches flag bit 8+i in the same clock as a write that clears that bit, the flag ends up set.
- R5: A rising edge on `irq_in[i]` sets flag bit 8+i three clocks after the input is sampled (two synchroniser stages, then the edge detector). A held high level or a falling edge does not set the flag again.
- R6: `irq_out` equals the OR of (flag AND NOT mask) over bits 8 to 10 as that value stood one clock earlier (states QUIET=0, RAISED=1).
- R7: A masked line still sets its flag on a rising edge.
- R8: Flag bits outside 8 to 10 always read 0, even after a write of 1s. Mask bits outside 8 to 10 have no effect on `irq_out`.
- R9: Reads at byte offsets other than 0x0 and 0x2 return 0, and writes there change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 3 | Asynchronous event lines; bit i maps to flag bit 8+i |
| bus_addr | input | 4 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Combined interrupt request, registered |

## Verification
The main check sweeps every combination of the three lines pulsing against every combination of the three mask bits. For each combination it compares the flag readback and `irq_out` with values computed from the two 3-bit patterns. This separates latching from gating. Unrelated high mask bits are mixed into half the sweep to show that they do not matter. Directed sequences then cover:
- partial clears written as complements;
- the exact one-clock lag of `irq_out` after a mask write;
- a held level and a falling edge that must not set a flag again;
- an edge that lands on the same clock as its own clearing write;
- accesses to unused offsets.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int unsigned REG_W    = 16;
    localparam int unsigned ADDR_W   = 4;
    localparam logic [ADDR_W-1:0] OFS_MASK = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_FLAG = 4'h2;

    typedef enum logic {
        ST_QUIET  = 1'b0,
        ST_RAISED = 1'b1
    } out_state_e;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] rise
);
    for (genvar i = 0; i < N; i++) begin : g_line
        logic meta_q, sync_q, last_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                last_q <= 1'b0;
            end else begin
                meta_q <= raw[i];
                sync_q <= meta_q;
                last_q <= sync_q;
            end
        end

        assign rise[i] = sync_q & ~last_q;

        AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            rise[i] |=> !rise[i]); // R5
    end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] rise,
    input  logic         clr_wr,
    input  logic [N-1:0] keep,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic drop;
        assign drop = clr_wr & ~keep[i];

        always_ff @(posedge clk) begin
            if (!rst_n) flags[i] <= 1'b0;
            else        flags[i] <= (flags[i] & ~drop) | rise[i];
        end

        AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            rise[i] |=> flags[i]); // R4
        AST_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !(clr_wr && !keep[i])) |=> flags[i]); // R2
        AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
            (!flags[i] && !rise[i]) |=> !flags[i]); // R5
    end
endmodule

// File: rtl/irq_out_fsm.sv
module irq_out_fsm
    import irq_agg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    output logic irq_out
);
    out_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:  if (pending)  state_d = ST_RAISED;
            ST_RAISED: if (!pending) state_d = ST_QUIET;
            default:   state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_out = (state_q == ST_RAISED);
    end

    AST_RAISE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        pending |=> irq_out); // R6
    AST_DROP_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |=> !irq_out); // R6
endmodule

// File: rtl/irq_edge_agg.sv
module irq_edge_agg
    import irq_agg_pkg::*;
#(
    parameter int unsigned LINE_LO  = 8,
    parameter int unsigned LINE_CNT = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LINE_CNT-1:0] irq_in,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [REG_W-1:0]    bus_wdata,
    output logic [REG_W-1:0]    bus_rdata,
    output logic                irq_out
);
    localparam logic [REG_W-1:0] LINE_SET = REG_W'(((1 << LINE_CNT) - 1) << LINE_LO);

    logic [LINE_CNT-1:0] rise, flags, live_mask;
    logic [REG_W-1:0]    mask_q, flag_view;
    logic                sel_mask, sel_flag, pending;

    assign sel_mask = (bus_addr == OFS_MASK);
    assign sel_flag = (bus_addr == OFS_FLAG);

    irq_edge_sync #(.N(LINE_CNT)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (irq_in),
        .rise (rise)
    );

    irq_flag_bank #(.N(LINE_CNT)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .rise  (rise),
        .clr_wr(bus_wr & sel_flag),
        .keep  (bus_wdata[LINE_LO +: LINE_CNT]),
        .flags (flags)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                 mask_q <= LINE_SET;
        else if (bus_wr && sel_mask) mask_q <= bus_wdata;
    end

    assign live_mask = mask_q[LINE_LO +: LINE_CNT];
    assign pending   = |(flags & ~live_mask);
    assign flag_view = REG_W'(flags) << LINE_LO;

    always_comb begin
        if (sel_mask)      bus_rdata = mask_q;
        else if (sel_flag) bus_rdata = flag_view;
        else               bus_rdata = '0;
    end

    irq_out_fsm u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .pending(pending),
        .irq_out(irq_out)
    );

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && sel_mask) |=> $stable(mask_q)); // R9
    AST_FLAG_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_view & ~LINE_SET) == '0); // R8
endmodule

// File: tb/irq_edge_agg_test.sv
module irq_edge_agg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  irq_in = '0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_edge_agg uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse(input logic [2:0] p);
        @(posedge clk); #1 irq_in = p;
        @(posedge clk); #1 irq_in = '0;
        wait_clk(5);
    endtask

    initial begin
        logic [15:0] rd;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(1);

        // R1 reset state
        bus_read(4'h0, rd); check("R1 mask", rd, 16'h0700);
        bus_read(4'h2, rd); check("R1 flag", rd, 16'h0000);
        check("R1 irq_out", 16'(irq_out), 16'h0);

        // Sweep: line patterns x mask patterns (R5, R6, R7, R8)
        for (int p = 0; p < 8; p++) begin
            for (int m = 0; m < 8; m++) begin
                logic [15:0] junk, mk;
                junk = ((p + m) % 2 == 1) ? 16'hF8FF : 16'h0000;
                mk = 16'(m << 8) | junk;
                bus_write(4'h2, 16'h0000);
                bus_write(4'h0, mk);
                pulse(3'(p));
                bus_read(4'h2, rd);
                check("R5/R7 sweep flag", rd, 16'(p << 8));
                check("R6/R8 sweep irq_out", 16'(irq_out), 16'(|(3'(p) & ~3'(m))));
            end
        end

        // R2 partial clear by complement
        bus_write(4'h2, 16'h0000);
        bus_write(4'h0, 16'h0700);
        pulse(3'b111);
        bus_write(4'h2, 16'hFDFF);
        bus_read(4'h2, rd); check("R2 clear bit 9", rd, 16'h0500);
        bus_write(4'h2, 16'hFFFF);
        bus_read(4'h2, rd); check("R2/R8 write ones keeps", rd, 16'h0500);

        // R6 exact lag after mask write, R3 readback
        check("R3 masked low", 16'(irq_out), 16'h0);
        bus_write(4'h0, 16'h0600);
        check("R6 lag cycle0", 16'(irq_out), 16'h0);
        wait_clk(1);
        check("R6 lag cycle1", 16'(irq_out), 16'h1);
        bus_read(4'h0, rd); check("R3 mask readback", rd, 16'h0600);
        bus_write(4'h0, 16'h0700);
        wait_clk(1);
        check("R3 0x0700 blocks all", 16'(irq_out), 16'h0);

        // R9 unused offsets
        bus_write(4'h4, 16'h0000);
        bus_write(4'h6, 16'h0000);
        bus_read(4'h0, rd); check("R9 mask untouched", rd, 16'h0700);
        bus_read(4'h2, rd); check("R9 flag untouched", rd, 16'h0500);
        bus_read(4'h4, rd); check("R9 read zero", rd, 16'h0000);

        // R5 held level and falling edge do not set again
        bus_write(4'h2, 16'h0000);
        @(posedge clk); #1 irq_in = 3'b010;
        wait_clk(5);
        bus_read(4'h2, rd); check("R5 rising sets", rd, 16'h0200);
        bus_write(4'h2, 16'hFDFF);
        wait_clk(6);
        bus_read(4'h2, rd); check("R5 level no reset", rd, 16'h0000);
        irq_in = 3'b000;
        wait_clk(6);
        bus_read(4'h2, rd); check("R5 falling no set", rd, 16'h0000);

        // R4 edge on same clock as clearing write
        pulse(3'b001);
        bus_read(4'h2, rd); check("R4 pre flag", rd, 16'h0100);
        @(posedge clk); #1 irq_in = 3'b001;
        @(posedge clk);
        @(posedge clk);
        bus_write(4'h2, 16'hFEFF);
        bus_read(4'h2, rd); check("R4 edge beats clear", rd, 16'h0100);
        irq_in = 3'b000;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule